// File: doc/BRIEF.md
# Cascadable Four-Bit ALU Slice with Eight-Bit Chain

This block is a purely combinational arithmetic logic unit built from identical four-bit slices. Each slice takes two operands, a three-bit operation code and a carry input. It returns a result as wide as its operands, a carry output and a signed-overflow flag. The eight operation codes cover constant clear, constant set, three arithmetic forms and three bitwise forms.

Subtraction is done by adding the inverted subtrahend. The carry input supplies the missing `+1`, so a borrow-free subtraction needs carry in = 1. Slices ripple-cascade: each slice's carry-out drives the carry-in of the next more significant slice. The top module chains two slices into an eight-bit unit. Its overflow flag is taken from the most significant slice.

Top module: `alu_chain`

## Requirements
- R1: Operation code 000 forces the result to all zeros.
- R2: Operation code 001 gives `{carry_out, result}` = `opb + ~opa + carry_in` over the full chain width, which is the reverse subtraction B minus A.
- R3: Operation code 010 gives `{carry_out, result}` = `opa + ~opb + carry_in`. For example, 0x04, 0x01 with carry_in = 1 yields 0x03 with carry_out = 1.
- R4: Operation code 011 gives `{carry_out, result}` = `opa + opb + carry_in`.
- R5: Operation code 100 gives the bitwise XOR of the operands.
- R6: Operation code 101 gives the bitwise OR of the operands. For example, 0x04 OR 0x01 yields 0x05.
- R7: Operation code 110 gives the bitwise AND of the operands.
- R8: Operation code 111 forces the result to all ones.
- R9: For codes 000, 100, 101, 110 and 111, carry_out and overflow are both 0, whatever carry_in is.
- R10: For codes 001, 010 and 011, overflow is 1 exactly when the two's-complement value of the sum lies outside the signed range of the chain width.
- R11: The carry produced by a lower slice feeds the next slice, so arithmetic results are correct over the full chain width. Outputs follow inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| op_sel | input | 3 | Operation code (000 clear, 001 B-A, 010 A-B, 011 A+B, 100 XOR, 101 OR, 110 AND, 111 set) |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Carry out of the most significant slice |
| overflow | output | 1 | Signed overflow of arithmetic codes |

## Verification
Carry-out and signed overflow can both be raised by the same operation. So can a carry crossing the slice boundary at bit 4 and an overflow at bit 7. The sweep provokes these cases with operand pairs such as 0x80 + 0x80, 0x7F + 0x01 and 0xFF - 0x80, with both carry-in values. It judges each flag on its own against a carry and a signed range computed with integer arithmetic in the bench. A design that derives one flag from the other, or that drops the inter-slice carry, then disagrees on at least one of those pairs.

// File: rtl/alu_chain_pkg.sv
package alu_chain_pkg;

   typedef enum logic [2:0] {
      OP_CLEAR = 3'b000,
      OP_RSUB  = 3'b001,
      OP_SUB   = 3'b010,
      OP_ADD   = 3'b011,
      OP_XOR   = 3'b100,
      OP_OR    = 3'b101,
      OP_AND   = 3'b110,
      OP_SET   = 3'b111
   } alu_op_e;

   function automatic logic op_is_arith(input alu_op_e op);
      return (op == OP_RSUB) || (op == OP_SUB) || (op == OP_ADD);
   endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
   import alu_chain_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  alu_op_e            op,
   input  logic [WIDTH-1:0]   a_val,
   input  logic [WIDTH-1:0]   b_val,
   output logic [WIDTH-1:0]   x_val,
   output logic [WIDTH-1:0]   y_val,
   output logic               arith
);
   always_comb begin
      x_val = a_val;
      y_val = b_val;
      unique case (op)
         OP_RSUB: begin x_val = b_val; y_val = ~a_val; end
         OP_SUB:  begin x_val = a_val; y_val = ~b_val; end
         default: ;
      endcase
   end

   assign arith = op_is_arith(op);
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] x_val,
   input  logic [WIDTH-1:0] y_val,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum,
   output logic             c_out,
   output logic             c_msb
);
   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = c_in;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]  = x_val[i] ^ y_val[i] ^ cy[i];
         assign cy[i+1] = (x_val[i] & y_val[i]) | (cy[i] & (x_val[i] ^ y_val[i]));
      end
      assign c_out = cy[WIDTH];
      assign c_msb = cy[WIDTH-1];
   end else begin : g_vector
      logic [WIDTH-1:0] low;
      logic [1:0]       top;
      assign low   = {1'b0, x_val[WIDTH-2:0]} + {1'b0, y_val[WIDTH-2:0]}
                   + {{(WIDTH-1){1'b0}}, c_in};
      assign c_msb = low[WIDTH-1];
      assign top   = {1'b0, x_val[WIDTH-1]} + {1'b0, y_val[WIDTH-1]} + {1'b0, c_msb};
      assign sum   = {top[0], low[WIDTH-2:0]};
      assign c_out = top[1];
   end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_chain_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a_val,
   input  logic [WIDTH-1:0] b_val,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      unique case (op)
         OP_XOR:  res = a_val ^ b_val;
         OP_OR:   res = a_val | b_val;
         OP_AND:  res = a_val & b_val;
         OP_SET:  res = '1;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_chain_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  alu_op_e          op,
   input  logic             c_in,
   output logic [WIDTH-1:0] f_out,
   output logic             c_out,
   output logic             v_out
);
   logic [WIDTH-1:0] x_val, y_val, sum, lres;
   logic             arith, add_co, add_cm;

   alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .op(op), .a_val(a_in), .b_val(b_in),
      .x_val(x_val), .y_val(y_val), .arith(arith)
   );

   alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .x_val(x_val), .y_val(y_val), .c_in(c_in),
      .sum(sum), .c_out(add_co), .c_msb(add_cm)
   );

   alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .op(op), .a_val(a_in), .b_val(b_in), .res(lres)
   );

   assign f_out = arith ? sum : lres;
   assign c_out = arith & add_co;
   assign v_out = arith & (add_co ^ add_cm);
endmodule

// File: rtl/alu_chain.sv
module alu_chain
   import alu_chain_pkg::*;
#(
   parameter int SLICE_W    = 4,
   parameter int NUM_SLICES = 2,
   parameter bit RIPPLE     = 1'b1,
   localparam int TOTAL_W   = SLICE_W * NUM_SLICES
) (
   input  logic [TOTAL_W-1:0] opa,
   input  logic [TOTAL_W-1:0] opb,
   input  logic [2:0]         op_sel,
   input  logic               carry_in,
   output logic [TOTAL_W-1:0] result,
   output logic               carry_out,
   output logic               overflow
);
   if (SLICE_W < 2) begin : g_bad_width
      $error("alu_chain: SLICE_W must be at least 2");
   end
   if (NUM_SLICES < 1) begin : g_bad_count
      $error("alu_chain: NUM_SLICES must be at least 1");
   end

   alu_op_e               op;
   logic [NUM_SLICES:0]   cc;
   logic [NUM_SLICES-1:0] v_all;

   assign op    = alu_op_e'(op_sel);
   assign cc[0] = carry_in;

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      alu_slice #(.WIDTH(SLICE_W), .RIPPLE(RIPPLE)) u_slice (
         .a_in (opa[s*SLICE_W +: SLICE_W]),
         .b_in (opb[s*SLICE_W +: SLICE_W]),
         .op   (op),
         .c_in (cc[s]),
         .f_out(result[s*SLICE_W +: SLICE_W]),
         .c_out(cc[s+1]),
         .v_out(v_all[s])
      );
   end

   assign carry_out = cc[NUM_SLICES];
   assign overflow  = v_all[NUM_SLICES-1];
endmodule

// File: rtl/alu_chain_checker.sv
module alu_chain_checker #(
   parameter int W  = 8,
   parameter int NS = 2
) (
   input logic [W-1:0]  opa,
   input logic [W-1:0]  opb,
   input logic [2:0]    op_sel,
   input logic          carry_in,
   input logic [W-1:0]  result,
   input logic          carry_out,
   input logic          overflow,
   input logic [NS:0]   cc,
   input logic [NS-1:0] v_all
);
   logic [W:0] add_ref;
   logic       known, is_logic;

   assign known    = !$isunknown({opa, opb, op_sel, carry_in});
   assign is_logic = (op_sel == 3'b000) || op_sel[2];
   assign add_ref  = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, carry_in};

   always_comb begin
      if (known) begin
         if (op_sel == 3'b000)
            AST_CLEAR_ZERO: assert (result == '0); // R1
         if (op_sel == 3'b111)
            AST_SET_ONES: assert (result == '1); // R8
         if (is_logic)
            AST_LOGIC_NO_FLAGS: assert (!carry_out && !overflow && v_all == '0); // R9
         if (is_logic)
            AST_LOGIC_NO_CHAIN_CARRY: assert (cc[NS:1] == '0); // R11
         if (op_sel == 3'b011)
            AST_ADD_VALUE: assert ({carry_out, result} == add_ref); // R4
         if (op_sel == 3'b011)
            AST_ADD_OVERFLOW: assert (overflow == ((opa[W-1] == opb[W-1]) && (result[W-1] != opa[W-1]))); // R10
         if (op_sel == 3'b101)
            AST_OR_VALUE: assert ((result & ~(opa | opb)) == '0 && (result | ~(opa | opb)) == '1); // R6
      end
   end
endmodule

bind alu_chain alu_chain_checker #(.W(TOTAL_W), .NS(NUM_SLICES)) u_checker (
   .opa(opa), .opb(opb), .op_sel(op_sel), .carry_in(carry_in),
   .result(result), .carry_out(carry_out), .overflow(overflow),
   .cc(cc), .v_all(v_all)
);

// File: tb/alu_chain_bench.sv
module alu_chain_bench;
   logic       clk = 1'b0;
   logic [7:0] opa, opb, result;
   logic [2:0] op_sel;
   logic       carry_in, carry_out, overflow;
   int         n_chk = 0, n_bad = 0, cyc = 0;

   always #2 clk = ~clk;

   alu_chain u_alu_chain (
      .opa(opa), .opb(opb), .op_sel(op_sel), .carry_in(carry_in),
      .result(result), .carry_out(carry_out), .overflow(overflow)
   );

   function automatic string op_tag(input int op);
      case (op)
         0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
         4: return "R5"; 5: return "R6"; 6: return "R7"; default: return "R8";
      endcase
   endfunction

   task automatic report(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s op=%0d a=%02h b=%02h ci=%0d: actual=%0h expected=%0h",
                  req, what, op_sel, opa, opb, carry_in, act, exp);
      end
   endtask

   task automatic run_vec(input int a, input int b, input int op, input int ci);
      int e_res, e_co, e_ov, s_val, raw;
      int sa, sb;
      @(posedge clk);
      opa = a[7:0]; opb = b[7:0]; op_sel = op[2:0]; carry_in = ci[0];
      sa = (a >= 128) ? a - 256 : a;
      sb = (b >= 128) ? b - 256 : b;
      e_co = 0; e_ov = 0; raw = 0; s_val = 0;
      case (op)
         0: e_res = 0;
         1: begin raw = b + (255 - a) + ci; s_val = sb - sa - 1 + ci; end
         2: begin raw = a + (255 - b) + ci; s_val = sa - sb - 1 + ci; end
         3: begin raw = a + b + ci;         s_val = sa + sb + ci;     end
         4: e_res = a ^ b;
         5: e_res = a | b;
         6: e_res = a & b;
         default: e_res = 255;
      endcase
      if (op >= 1 && op <= 3) begin
         e_res = raw % 256;
         e_co  = raw / 256;
         e_ov  = (s_val > 127 || s_val < -128) ? 1 : 0;
      end
      @(negedge clk);
      report(op_tag(op), "result", int'(result), e_res);
      if (op >= 1 && op <= 3) begin
         report("R11", "carry_out", int'(carry_out), e_co);   // R11 chain carry
         report("R10", "overflow", int'(overflow), e_ov);     // R10 signed range
      end else begin
         report("R9", "flags", int'({carry_out, overflow}), 0); // R9
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int corner [7] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF};
      opa = 8'h00; opb = 8'h00; op_sel = 3'b000; carry_in = 1'b0;
      @(negedge clk);
      // initial state: clear code with zero inputs (R1)
      report("R1", "initial result", int'(result), 0);
      // named examples
      run_vec(8'h04, 8'h01, 2, 1); // R3: 4 - 1 = 3
      run_vec(8'h04, 8'h01, 5, 0); // R6: 4 | 1 = 5
      // corner pairs provoking carry and overflow together, slice boundary crossing
      for (int op = 0; op < 8; op++)
         for (int ci = 0; ci < 2; ci++)
            for (int i = 0; i < 7; i++)
               for (int j = 0; j < 7; j++)
                  run_vec(corner[i], corner[j], op, ci);
      // near-exhaustive sweep: every A, sixteen B values
      for (int op = 0; op < 8; op++)
         for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < 256; a++)
               for (int k = 0; k < 16; k++)
                  run_vec(a, k * 17, op, ci);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule